// File: doc/BRIEF.md
# SMBus Register Target

This block is a two-wire bus target that gives a bank of eight byte-wide registers to a bus master. It takes raw SCL and SDA, brings them into the system clock through two-flop synchronizers, and pulls SDA low through an open-drain enable. It finds START, repeated START and STOP, and it checks the address byte against three targets: its own address, a broadcast address for writes to every device, and the SMBus Alert Response Address.

It handles byte and word transactions in both directions. A write sends a command byte, whose low three bits become the register pointer, and then a data byte. The block passes the data byte to the register file as a one-cycle write strobe with an address and data. A read uses a repeated START. The block then shifts out the register that the pointer selects and sends the same register again each time the master acknowledges. While the alert-pending input is high, a read of the Alert Response Address returns the block's own address and raises a one-cycle done pulse.

Top module: `smb_reg_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. At either condition SDA is released on the next cycle. After a STOP, clocked bits get no response until a START.
- R2: The own address is `{2'b10, addr_cfg_i[4:0]}`. It is acknowledged with R/W set to 0 or to 1. Any other address that is not a special one gets no acknowledge, and the bus is then ignored until START or STOP.
- R3: Address 7'b1011111 with R/W=0 is acknowledged and handled as a write when `mass_wr_en_i` is 1. When `mass_wr_en_i` is 0 it gets no acknowledge and causes no write.
- R4: The command byte is acknowledged. Its bits [2:0] become the register pointer, which drives `reg_raddr_o`. Bits [7:3] are ignored.
- R5: The first data byte after the command is acknowledged. It raises `reg_we_o` for one cycle, with `reg_waddr_o` equal to the pointer and `reg_wdata_o` equal to the byte, in a cycle where SCL is low.
- R6: Every later data byte in the same write is acknowledged and causes no write strobe.
- R7: After a read address is acknowledged, `reg_rdata_i` is sent MSB first, and the SDA drive starts only while SCL is low. If the master acknowledges, the same register is sent again.
- R8: After a master NACK the block releases SDA and does not drive it until the next START or STOP.
- R9: A read of address 7'b0001100 is acknowledged only while `alert_pending_i` is 1. The reply byte is the own address in bits [7:1] with bit 0 equal to 0. `ara_done_o` pulses for one cycle at the SCL rise of the master's acknowledge bit.
- R10: When the block is the receiver, it holds SDA low over the whole ninth SCL pulse of each byte it acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock |
| sda_i | input | 1 | Raw bus data, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_cfg_i | input | 5 | Low five bits of the own address |
| mass_wr_en_i | input | 1 | Enables the broadcast write address |
| alert_pending_i | input | 1 | An alert is waiting to be claimed |
| ara_done_o | output | 1 | One-cycle pulse when the alert reply is complete |
| reg_we_o | output | 1 | Register write strobe |
| reg_waddr_o | output | 3 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | 3 | Register read address (the pointer) |
| reg_rdata_i | input | 8 | Read data for `reg_raddr_o` |

## Verification
The bench uses the default parameters: 8-bit data, a 3-bit pointer and two synchronizer stages. With these values the 5-bit address configuration is small enough to sweep all 32 settings. Each setting runs a write and a read-back with repeat to a register taken from the configuration value, so every pointer value is used four times. Each setting also sends a mismatched address that differs in the R/W-adjacent bit. The bench also tests the broadcast address with the enable set and cleared, the alert address with and without a pending alert, and bit clocking without a START.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int ADDR_W = 7;
  localparam int CFG_W  = ADDR_W - 2;
  localparam logic [1:0]        OWN_HI    = 2'b10;
  localparam logic [ADDR_W-1:0] BCAST_ADR = 7'b1011111;
  localparam logic [ADDR_W-1:0] ALERT_ADR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_DATA, PH_EXTRA
  } byte_ph_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  // Bus lines idle high, so reset to ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mass_wr_en_i,
  input  logic              alert_pending_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ara_done_o
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  bus_st_e           st_q;
  byte_ph_e          ph_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              full_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q, wdata_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              oe_q, we_q, ara_done_q, go_tx_q, is_ara_q, mack_q;

  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rd, own_hit, bcast_hit, alert_hit, hit_rd, hit_wr;
  logic [DATA_W-1:0] tx_src;

  assign rx_addr   = rx_sh_q[DATA_W-1 -: ADDR_W];
  assign rx_rd     = rx_sh_q[0];
  assign own_hit   = (rx_addr == own_addr_i);
  assign bcast_hit = (rx_addr == BCAST_ADR) & mass_wr_en_i;
  assign alert_hit = (rx_addr == ALERT_ADR) & alert_pending_i;
  assign hit_rd    = rx_rd & (own_hit | alert_hit);
  assign hit_wr    = ~rx_rd & (own_hit | bcast_hit);
  assign tx_src    = is_ara_q ? {own_addr_i, {(DATA_W-ADDR_W){1'b0}}} : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_ADDR;
      bit_cnt_q  <= '0;
      full_q     <= 1'b0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      wdata_q    <= '0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      we_q       <= 1'b0;
      ara_done_q <= 1'b0;
      go_tx_q    <= 1'b0;
      is_ara_q   <= 1'b0;
      mack_q     <= 1'b0;
    end else begin
      we_q       <= 1'b0;
      ara_done_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        ph_q      <= PH_ADDR;
        bit_cnt_q <= '0;
        full_q    <= 1'b0;
        oe_q      <= 1'b0;
        is_ara_q  <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        oe_q     <= 1'b0;
        is_ara_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i && !full_q) begin
              rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_i};
              if (bit_cnt_q == LAST) full_q <= 1'b1;
              else                   bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && full_q) begin
              full_q    <= 1'b0;
              bit_cnt_q <= '0;
              go_tx_q   <= 1'b0;
              unique case (ph_q)
                PH_ADDR: begin
                  if (hit_rd) begin
                    st_q     <= ST_ACK;
                    oe_q     <= 1'b1;
                    go_tx_q  <= 1'b1;
                    is_ara_q <= ~own_hit;
                  end else if (hit_wr) begin
                    st_q <= ST_ACK;
                    oe_q <= 1'b1;
                    ph_q <= PH_CMD;
                  end else begin
                    st_q <= ST_SKIP;
                  end
                end
                PH_CMD: begin
                  ptr_q <= rx_sh_q[PTR_W-1:0];
                  ph_q  <= PH_DATA;
                  st_q  <= ST_ACK;
                  oe_q  <= 1'b1;
                end
                PH_DATA: begin
                  we_q    <= 1'b1;
                  wdata_q <= rx_sh_q;
                  ph_q    <= PH_EXTRA;
                  st_q    <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: begin
                  st_q <= ST_ACK;
                  oe_q <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (go_tx_q) begin
                tx_sh_q <= tx_src;
                oe_q    <= ~tx_src[DATA_W-1];
                st_q    <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == LAST) begin
                oe_q <= 1'b0;
                st_q <= ST_MACK;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
                oe_q      <= ~tx_sh_q[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q     <= ~sda_i;
              ara_done_q <= is_ara_q;
            end else if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (mack_q) begin
                tx_sh_q <= tx_src;
                oe_q    <= ~tx_src[DATA_W-1];
                st_q    <= ST_TX;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign we_o       = we_q;
  assign ptr_o      = ptr_q;
  assign wdata_o    = wdata_q;
  assign ara_done_o = ara_done_q;
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PTR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [CFG_W-1:0]  addr_cfg_i,
  input  logic              mass_wr_en_i,
  input  logic              alert_pending_i,
  output logic              ara_done_o,
  output logic              reg_we_o,
  output logic [PTR_W-1:0]  reg_waddr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [PTR_W-1:0]  reg_raddr_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {OWN_HI, addr_cfg_i};

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  smb_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_target_fsm #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .scl_rise_i      (scl_rise),
    .scl_fall_i      (scl_fall),
    .start_i         (start_det),
    .stop_i          (stop_det),
    .sda_i           (sda_s),
    .own_addr_i      (own_addr),
    .mass_wr_en_i    (mass_wr_en_i),
    .alert_pending_i (alert_pending_i),
    .rdata_i         (reg_rdata_i),
    .sda_oe_o        (sda_oe_o),
    .we_o            (reg_we_o),
    .ptr_o           (ptr),
    .wdata_o         (reg_wdata_o),
    .ara_done_o      (ara_done_o)
  );

  assign reg_waddr_o = ptr;
  assign reg_raddr_o = ptr;
endmodule

// File: rtl/smb_reg_target_chk.sv
module smb_reg_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic ara_done_o
);
  assert_start_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
  assert_drive_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));
  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  assert_we_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !$past(scl_s));
  assert_ara_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_done_o |=> !ara_done_o);
  assert_ara_we_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && ara_done_o));
endmodule

bind smb_reg_target smb_reg_target_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .ara_done_o (ara_done_o)
);

// File: tb/smb_reg_target_tb.sv
module smb_reg_target_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [4:0] cfg = '0;
  logic       mass_en = 1'b1, alert = 1'b0;
  logic       ara_done, we;
  logic [2:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic [7:0] regs [8];
  logic [7:0] exp_regs [8];
  int         n_chk = 0, n_err = 0, we_cnt = 0, ara_cnt = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rdata    = regs[raddr];

  smb_reg_target dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .sda_oe_o        (sda_oe),
    .addr_cfg_i      (cfg),
    .mass_wr_en_i    (mass_en),
    .alert_pending_i (alert),
    .ara_done_o      (ara_done),
    .reg_we_o        (we),
    .reg_waddr_o     (waddr),
    .reg_wdata_o     (wdata),
    .reg_raddr_o     (raddr),
    .reg_rdata_i     (rdata)
  );

  // Register file neighbour
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n && we)       we_cnt++;
    if (rst_n && ara_done) ara_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(5); sda_m = 1'b0; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(5); sda_m = b[i]; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0;
    end
    tick(5); sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(1);
    ack = !sda_line;
    tick(4);
    ack = ack & !sda_line;  // R10: low across the pulse
    tick(4);
    ack = ack & !sda_line;
    tick(1);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(10); scl_m = 1'b1;
      tick(5);  b[i] = sda_line;
      tick(5);  scl_m = 1'b0;
    end
    tick(5); sda_m = !mack; tick(5);
    scl_m = 1'b1; tick(10);
    scl_m = 1'b0; tick(5);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit         ack;
    logic [7:0] b;
    logic [6:0] own;
    int         we0, ara0;
    for (int i = 0; i < 8; i++) exp_regs[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(we == 1'b0 && ara_done == 1'b0, "R1 reset strobes", {we, ara_done}, 0);

    for (int c = 0; c < 32; c++) begin
      logic [2:0] k;
      logic [7:0] d;
      cfg = 5'(c);
      own = {2'b10, cfg};
      k   = 3'(c % 8);
      d   = 8'((c * 37 + 11) & 8'hff);
      // write byte then ignored extra byte
      bus_start();
      send_byte({own, 1'b0}, ack);
      chk(ack, "R2 own write address ack", ack, 1);
      send_byte({5'b10101, k}, ack);
      chk(ack, "R4 command ack", ack, 1);
      chk(raddr == k, "R4 pointer low bits", raddr, k);
      we0 = we_cnt;
      send_byte(d, ack);
      chk(ack, "R10 data ack", ack, 1);
      exp_regs[k] = d;
      chk(regs[k] == exp_regs[k], "R5 register written", regs[k], exp_regs[k]);
      send_byte(~d, ack);
      chk(ack, "R6 extra byte ack", ack, 1);
      bus_stop();
      chk(regs[k] == exp_regs[k] && we_cnt == we0 + 1, "R6 extra byte ignored",
          regs[k], exp_regs[k]);
      // read with repeat, then NACK
      bus_start();
      send_byte({own, 1'b0}, ack);
      send_byte({5'b01010, k}, ack);
      bus_start();
      send_byte({own, 1'b1}, ack);
      chk(ack, "R7 own read address ack", ack, 1);
      recv_byte(b, 1'b1);
      chk(b == exp_regs[k], "R7 read data", b, exp_regs[k]);
      recv_byte(b, 1'b0);
      chk(b == exp_regs[k], "R7 repeated read data", b, exp_regs[k]);
      chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
      recv_byte(b, 1'b0);
      chk(b == 8'hff, "R8 no drive after NACK", b, 8'hff);
      bus_stop();
      // mismatched address
      bus_start();
      send_byte({own ^ 7'h01, 1'b1}, ack);
      chk(!ack, "R2 foreign address no ack", ack, 0);
      bus_stop();
    end

    // broadcast write enabled / disabled
    cfg = 5'd3;
    own = {2'b10, cfg};
    mass_en = 1'b1;
    bus_start();
    send_byte({7'b1011111, 1'b0}, ack);
    chk(ack, "R3 broadcast ack when enabled", ack, 1);
    send_byte(8'h02, ack);
    send_byte(8'ha5, ack);
    bus_stop();
    exp_regs[2] = 8'ha5;
    chk(regs[2] == exp_regs[2], "R3 broadcast write", regs[2], exp_regs[2]);
    mass_en = 1'b0;
    we0 = we_cnt;
    bus_start();
    send_byte({7'b1011111, 1'b0}, ack);
    chk(!ack, "R3 broadcast no ack when disabled", ack, 0);
    bus_stop();
    chk(we_cnt == we0 && regs[2] == exp_regs[2], "R3 no write when disabled", we_cnt, we0);

    // clocking without a START after STOP
    scl_m = 1'b0; tick(10);
    send_byte({own, 1'b0}, ack);
    chk(!ack, "R1 ignored without START", ack, 0);
    bus_stop();

    // alert response address
    alert = 1'b0;
    ara0 = ara_cnt;
    bus_start();
    send_byte({7'b0001100, 1'b1}, ack);
    chk(!ack, "R9 no ack without pending alert", ack, 0);
    bus_stop();
    chk(ara_cnt == ara0, "R9 no done without alert", ara_cnt, ara0);
    alert = 1'b1;
    bus_start();
    send_byte({7'b0001100, 1'b1}, ack);
    chk(ack, "R9 ack with pending alert", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == {own, 1'b0}, "R9 reply byte", b, {own, 1'b0});
    chk(ara_cnt == ara0 + 1, "R9 done pulse", ara_cnt, ara0 + 1);
    bus_stop();
    alert = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule